// File: doc/BRIEF.md
# Dual-Mode Timer Counter Core

This block is the counting engine of a general-purpose peripheral timer. A 32-bit up-counter runs on the functional clock. One control word programs it. That word starts and stops the count, turns on automatic reload at overflow, enables an optional power-of-two prescaler and enables a compare against a match value. It also picks the capture edge and configures a shared event pin that can be an output or an input. A simple synchronous write port stands in for the register bus. The counter value, the capture register, the status flags and the event-pin signals are wired straight out as ports.

The counter is governed by a two-state machine. In `ST_IDLE` the counter holds. The transition *launch* (`ST_IDLE` to `ST_RUN`) is taken on the clock after the run bit of the control word reads 1. In `ST_RUN` the counter advances on each prescaler tick. The transition *halt* (`ST_RUN` to `ST_IDLE`) is taken either when software clears the run bit, or in the same clock as an overflow while reload is off, which also clears the run bit.

Three events feed the status flags: overflow, compare-match and input capture. These flags, masked by an interrupt-enable register, drive the interrupt output. The same flags, masked by a wake-enable register, drive the wake output. The event pin idles at a programmable level and either toggles or pulses for one clock on the selected events.

Top module: `tmr_core`

Write addresses (3-bit): 0 control, 1 load value, 2 counter, 3 match value, 4 reload trigger, 5 status (write ones to clear), 6 interrupt enable, 7 wake enable. Status bits: 0 match, 1 overflow, 2 capture.

## Requirements
- R1: Setting control bit 0 (address 0) starts counting; counting begins on the second clock after the write. Clearing it halts the counter after at most one further increment, well inside 3.5 functional clocks.
- R2: With control bit 5 clear, a running counter advances by one every clock. A write to address 2 loads the counter directly, whether it is running or halted.
- R3: With control bit 5 set, the counter advances once every 2^(r+1) clocks, where r is the 3-bit ratio in control bits 4:2.
- R4: Overflow past all-ones with control bit 1 clear leaves the counter at zero, clears the run bit and halts counting.
- R5: Overflow past all-ones with control bit 1 set reloads the counter from the load value (address 1), and counting continues.
- R6: Any write to address 4 copies the load value into the counter on that clock, whether the counter is running or halted.
- R7: Overflow sets status bit 1. Writing a one to a status bit (address 5) clears it, and zeros leave bits unchanged. The interrupt output is the OR of status ANDed with the mask at address 6, and the wake output is the same with the mask at address 7.
- R8: With control bit 6 set, the counter advancing onto the match value (address 3) sets status bit 0. With bit 6 clear, no match is flagged.
- R9: The event pin rests at the level of control bit 7. Control bits 11:10 pick its events: 00 none, 01 overflow, 10 overflow or match, 11 match only.
- R10: With control bit 12 set, each selected event inverts the event pin. With it clear, the pin leaves its rest level for exactly one clock per event.
- R11: Control bits 9:8 pick the capture edge on the capture pin: 00 none, 01 rising, 10 falling, 11 both. A qualifying edge copies the counter into the capture register and sets status bit 2, three clocks after the pin changes.
- R12: With control bit 13 set, edges are ignored while status bit 2 is set, so the first captured value is kept until software clears the flag.
- R13: Control bit 14 sets the event-pin direction. When it is 1, the output enable is high and capture edges are ignored. When it is 0, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_o | output | 32 | Current counter value |
| capture_o | output | 32 | Last captured counter value |
| status_o | output | 3 | Event flags {capture, overflow, match} |
| evt_pin_o | output | 1 | Event/PWM pin level |
| evt_pin_oe_o | output | 1 | Event pin output enable |
| irq_o | output | 1 | Masked interrupt request |
| wake_o | output | 1 | Masked wake request |

## Verification
Register writes take effect on the clock edge that samples them, so counter loads, reloads, status clears and mask changes can be checked on the next half cycle. The first increment after a start lands on the second edge after the write, and an event-pin pulse sits on the same edge as the count that caused it. A capture lands three edges after the pin moves, because of the two-stage synchronizer and the edge register. The bench drives every input on the falling edge and samples on falling edges. It counts edges from the one that takes each write, so every expected value is compared in the exact cycle derived from these latencies. Rates are checked as count differences over whole prescaler periods, so the phase of the divider does not affect the result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_AW = 3;
    localparam int TMR_SW = 3;

    localparam logic [TMR_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [TMR_AW-1:0] A_LOAD  = 3'd1;
    localparam logic [TMR_AW-1:0] A_COUNT = 3'd2;
    localparam logic [TMR_AW-1:0] A_MATCH = 3'd3;
    localparam logic [TMR_AW-1:0] A_TRIG  = 3'd4;
    localparam logic [TMR_AW-1:0] A_STAT  = 3'd5;
    localparam logic [TMR_AW-1:0] A_IEN   = 3'd6;
    localparam logic [TMR_AW-1:0] A_WEN   = 3'd7;

    localparam int S_MATCH = 0;
    localparam int S_OVF   = 1;
    localparam int S_CAP   = 2;

    // Field layout is fixed by software decoding; bit 0 is at the bottom.
    typedef struct packed {
        logic       pin_out;     // 14
        logic       cap_single;  // 13
        logic       toggle;      // 12
        logic [1:0] trig_sel;    // 11:10
        logic [1:0] cap_edge;    // 9:8
        logic       pin_idle;    // 7
        logic       cmp_en;      // 6
        logic       pre_en;      // 5
        logic [2:0] pre_ratio;   // 4:2
        logic       reload_en;   // 1
        logic       run;         // 0
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               pre_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    localparam int DW = 1 << RATIO_W;

    logic [DW-1:0] div_q;
    logic [DW-1:0] lim;

    always_comb begin
        if (pre_en_i) lim = {DW{1'b1}} >> (DW - 1 - int'(ratio_i));
        else          lim = '0;
    end

    assign tick_o = en_i && (div_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n)      div_q <= '0;
        else if (!en_i)  div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    // R3
    pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en_i && tick_o) |=> (!tick_o || !pre_en_i));
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic [1:0]       edge_sel_i,
    input  logic             pin_out_i,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             take_o
);
    logic s1_q, s2_q, prev_q;
    logic rise, fall;

    assign rise   = s2_q & ~prev_q;
    assign fall   = ~s2_q & prev_q;
    assign take_o = !pin_out_i && !hold_i &&
                    ((edge_sel_i[0] && rise) || (edge_sel_i[1] && fall));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
            cap_o  <= '0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
            if (take_o) cap_o <= count_i;
        end
    end

    // R13
    dir_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out_i && $stable(pin_out_i)) |=> $stable(cap_o) || !pin_out_i);
endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovf_i,
    input  logic       match_i,
    input  logic [1:0] trig_sel_i,
    input  logic       toggle_i,
    input  logic       idle_i,
    output logic       pin_o
);
    logic evt;
    logic pin_q;

    always_comb begin
        unique case (trig_sel_i)
            2'b00:   evt = 1'b0;
            2'b01:   evt = ovf_i;
            2'b10:   evt = ovf_i | match_i;
            default: evt = match_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        pin_q <= 1'b0;
        else if (toggle_i) pin_q <= pin_q ^ evt;
        else               pin_q <= evt;
    end

    assign pin_o = idle_i ^ pin_q;

    // R10
    pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!toggle_i && !evt) |=> !pin_q);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [TMR_AW-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              cap_pin_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  capture_o,
    output logic [TMR_SW-1:0] status_o,
    output logic              evt_pin_o,
    output logic              evt_pin_oe_o,
    output logic              irq_o,
    output logic              wake_o
);
    tmr_ctrl_t         ctrl_q;
    tmr_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, load_q, match_q;
    logic [CNT_W-1:0]  cnt_inc, cnt_adv;
    logic [TMR_SW-1:0] stat_q, ien_q, wen_q, stat_clr;
    logic wr_ctrl, wr_load, wr_cnt, wr_match, wr_trig, wr_stat, wr_ien, wr_wen;
    logic run_en, tick, adv, at_top, ovf_evt, match_evt, one_shot_end;
    logic cap_take, cap_hold;

    assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_load  = wr_en_i && (wr_addr_i == A_LOAD);
    assign wr_cnt   = wr_en_i && (wr_addr_i == A_COUNT);
    assign wr_match = wr_en_i && (wr_addr_i == A_MATCH);
    assign wr_trig  = wr_en_i && (wr_addr_i == A_TRIG);
    assign wr_stat  = wr_en_i && (wr_addr_i == A_STAT);
    assign wr_ien   = wr_en_i && (wr_addr_i == A_IEN);
    assign wr_wen   = wr_en_i && (wr_addr_i == A_WEN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: launch and halt transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_q.run) state_d = ST_RUN;
            ST_RUN:  if (!ctrl_q.run || one_shot_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        run_en = 1'b0;
        unique case (state_q)
            ST_IDLE: run_en = 1'b0;
            ST_RUN:  run_en = 1'b1;
            default: run_en = 1'b0;
        endcase
    end

    tmr_prescale #(.RATIO_W(RATIO_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (run_en),
        .pre_en_i (ctrl_q.pre_en),
        .ratio_i  (ctrl_q.pre_ratio),
        .tick_o   (tick)
    );

    assign adv          = tick && !wr_cnt && !wr_trig;
    assign at_top       = (cnt_q == {CNT_W{1'b1}});
    assign cnt_inc      = cnt_q + 1'b1;
    assign ovf_evt      = adv && at_top;
    assign one_shot_end = ovf_evt && !ctrl_q.reload_en;
    assign cnt_adv      = at_top ? (ctrl_q.reload_en ? load_q : '0) : cnt_inc;
    assign match_evt    = adv && ctrl_q.cmp_en && (cnt_adv == match_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            load_q  <= '0;
            match_q <= '0;
        end else begin
            if (wr_load)  load_q  <= wr_data_i;
            if (wr_match) match_q <= wr_data_i;
            if (wr_cnt)       cnt_q <= wr_data_i;
            else if (wr_trig) cnt_q <= load_q;
            else if (adv)     cnt_q <= cnt_adv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)            ctrl_q     <= '0;
        else if (wr_ctrl)      ctrl_q     <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
        else if (one_shot_end) ctrl_q.run <= 1'b0;
    end

    assign cap_hold = ctrl_q.cap_single && stat_q[S_CAP];

    tmr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (cap_pin_i),
        .edge_sel_i (ctrl_q.cap_edge),
        .pin_out_i  (ctrl_q.pin_out),
        .hold_i     (cap_hold),
        .count_i    (cnt_q),
        .cap_o      (capture_o),
        .take_o     (cap_take)
    );

    tmr_outpin u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_i      (ovf_evt),
        .match_i    (match_evt),
        .trig_sel_i (ctrl_q.trig_sel),
        .toggle_i   (ctrl_q.toggle),
        .idle_i     (ctrl_q.pin_idle),
        .pin_o      (evt_pin_o)
    );

    assign stat_clr = wr_stat ? wr_data_i[TMR_SW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            ien_q  <= '0;
            wen_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | {cap_take, ovf_evt, match_evt};
            if (wr_ien) ien_q <= wr_data_i[TMR_SW-1:0];
            if (wr_wen) wen_q <= wr_data_i[TMR_SW-1:0];
        end
    end

    assign count_o      = cnt_q;
    assign status_o     = stat_q;
    assign evt_pin_oe_o = ctrl_q.pin_out;
    assign irq_o        = |(stat_q & ien_q);
    assign wake_o       = |(stat_q & wen_q);

    // R1
    run_needs_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> $past(ctrl_q.run));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_cnt && !wr_trig) |=> $stable(cnt_q));

    // R4
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ctrl_q.reload_en) |=> (cnt_q == '0 && state_q == ST_IDLE));

    // R7
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> stat_q[S_OVF]);

    // R11
    cap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |=> stat_q[S_CAP]);
endmodule

// File: tb/tb_tmr_core.sv
module tb_tmr_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        cap_pin;
    logic [31:0] count, capture;
    logic [2:0]  status;
    logic        pin, pin_oe, irq, wake;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] C_RUN    = 32'h1;
    localparam logic [31:0] C_RELOAD = 32'h2;
    localparam logic [31:0] C_PRE    = 32'h20;
    localparam logic [31:0] C_CMP    = 32'h40;
    localparam logic [31:0] C_IDLE1  = 32'h80;
    localparam logic [31:0] E_RISE   = 32'h100;
    localparam logic [31:0] E_FALL   = 32'h200;
    localparam logic [31:0] E_BOTH   = 32'h300;
    localparam logic [31:0] T_OVF    = 32'h400;
    localparam logic [31:0] T_MATCH  = 32'hC00;
    localparam logic [31:0] C_TOGGLE = 32'h1000;
    localparam logic [31:0] C_SINGLE = 32'h2000;
    localparam logic [31:0] C_PINOUT = 32'h4000;

    always #5 clk = ~clk;

    tmr_core dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .cap_pin_i(cap_pin), .count_o(count),
        .capture_o(capture), .status_o(status), .evt_pin_o(pin),
        .evt_pin_oe_o(pin_oe), .irq_o(irq), .wake_o(wake)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic halt();
        wr(3'd0, 32'h0);
        cyc(3);
    endtask

    task automatic set_pin(logic v);
        @(negedge clk);
        cap_pin = v;
        cyc(4);
    endtask

    task automatic t_reset();
        chk("R2 reset count", count, 32'h0);
        chk("R7 reset status", {29'h0, status}, 32'h0);
        chk("R9 reset pin", {31'h0, pin}, 32'h0);
        chk("R13 reset oe", {31'h0, pin_oe}, 32'h0);
        chk("R7 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] c0;
        wr(3'd2, 32'd100);
        wr(3'd0, C_RUN);
        cyc(1);
        chk("R1 no increment before second edge", count, 32'd100);
        cyc(10);
        chk("R2 one per clock", count, 32'd110);
        wr(3'd0, 32'h0);
        c0 = count;
        cyc(5);
        chk("R1 halt within one extra step", count, c0 + 32'd1);
        cyc(10);
        chk("R1 stays halted", count, c0 + 32'd1);
    endtask

    task automatic t_prescale(int r);
        logic [31:0] c1;
        int per;
        per = 1 << (r + 1);
        halt();
        wr(3'd2, 32'h0);
        wr(3'd0, C_RUN | C_PRE | (32'(r) << 2));
        cyc(20);
        c1 = count;
        cyc(per * 5);
        chk($sformatf("R3 ratio %0d rate", r), count - c1, 32'd5);
        halt();
    endtask

    task automatic t_oneshot();
        halt();
        wr(3'd2, 32'hFFFF_FFFE);
        wr(3'd5, 32'h7);
        wr(3'd0, C_RUN);
        cyc(2);
        chk("R4 reaches all-ones", count, 32'hFFFF_FFFF);
        cyc(5);
        chk("R4 wraps to zero", count, 32'h0);
        cyc(10);
        chk("R4 stays stopped", count, 32'h0);
        chk("R7 overflow flag", {29'h0, status}, 32'h2);
    endtask

    task automatic t_status();
        wr(3'd6, 32'h0);
        chk("R7 irq masked", {31'h0, irq}, 32'h0);
        wr(3'd6, 32'h2);
        chk("R7 irq on overflow", {31'h0, irq}, 32'h1);
        chk("R7 wake masked", {31'h0, wake}, 32'h0);
        wr(3'd7, 32'h2);
        chk("R7 wake on overflow", {31'h0, wake}, 32'h1);
        wr(3'd5, 32'h1);
        chk("R7 zero bit leaves flag", {29'h0, status}, 32'h2);
        wr(3'd5, 32'h2);
        chk("R7 write one clears", {29'h0, status}, 32'h0);
        chk("R7 irq drops", {31'h0, irq}, 32'h0);
        wr(3'd6, 32'h0);
        wr(3'd7, 32'h0);
    endtask

    task automatic t_reload();
        halt();
        wr(3'd1, 32'h1000);
        wr(3'd2, 32'hFFFF_FFFD);
        wr(3'd5, 32'h7);
        wr(3'd0, C_RUN | C_RELOAD);
        cyc(5);
        chk("R5 reload continues", count, 32'h1001);
        chk("R5 overflow flagged", {29'h0, status}, 32'h2);
        halt();
    endtask

    task automatic t_trigger();
        halt();
        wr(3'd1, 32'h55);
        wr(3'd2, 32'h10);
        wr(3'd4, 32'hDEAD);
        chk("R6 trigger reloads", count, 32'h55);
    endtask

    task automatic t_match();
        halt();
        wr(3'd5, 32'h7);
        wr(3'd3, 32'h205);
        wr(3'd2, 32'h200);
        wr(3'd0, C_RUN);
        cyc(10);
        halt();
        chk("R8 compare disabled no flag", {31'h0, status[0]}, 32'h0);
        wr(3'd2, 32'h200);
        wr(3'd0, C_RUN | C_CMP);
        cyc(10);
        halt();
        chk("R8 match flagged", {31'h0, status[0]}, 32'h1);
        wr(3'd5, 32'h7);
    endtask

    task automatic t_pulse();
        halt();
        wr(3'd3, 32'h203);
        wr(3'd2, 32'h200);
        wr(3'd0, C_RUN | C_CMP | T_MATCH);
        cyc(3);
        chk("R10 pulse not yet", {31'h0, pin}, 32'h0);
        cyc(1);
        chk("R10 pulse on match", {31'h0, pin}, 32'h1);
        cyc(1);
        chk("R10 pulse one clock", {31'h0, pin}, 32'h0);
        halt();
    endtask

    task automatic t_level();
        logic ok;
        wr(3'd0, C_IDLE1);
        chk("R9 rest level high", {31'h0, pin}, 32'h1);
        wr(3'd1, 32'hFFFF_FFFC);
        wr(3'd2, 32'hFFFF_FFFC);
        wr(3'd0, C_IDLE1 | C_RUN | C_RELOAD | C_TOGGLE);
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (pin !== 1'b1) ok = 1'b0;
        end
        chk("R9 field 00 drives nothing", {31'h0, ok}, 32'h1);
        halt();
    endtask

    task automatic t_toggle();
        logic p0;
        wr(3'd1, 32'hFFFF_FFFC);
        wr(3'd2, 32'hFFFF_FFFC);
        wr(3'd0, C_RUN | C_RELOAD | C_TOGGLE | T_OVF);
        cyc(4);
        p0 = pin;
        cyc(1);
        chk("R10 toggles on overflow", {31'h0, pin}, {31'h0, ~p0});
        cyc(3);
        chk("R10 holds between events", {31'h0, pin}, {31'h0, ~p0});
        cyc(1);
        chk("R10 toggles back", {31'h0, pin}, {31'h0, p0});
        halt();
    endtask

    task automatic t_capture();
        halt();
        wr(3'd2, 32'h77);
        wr(3'd0, E_RISE);
        wr(3'd5, 32'h7);
        set_pin(1'b1);
        chk("R11 rising captured", capture, 32'h77);
        chk("R11 capture flag", {31'h0, status[2]}, 32'h1);
        wr(3'd5, 32'h4);
        set_pin(1'b0);
        chk("R11 falling ignored in rising mode", {31'h0, status[2]}, 32'h0);
        wr(3'd0, E_FALL);
        wr(3'd2, 32'h88);
        set_pin(1'b1);
        chk("R11 rising ignored in falling mode", {31'h0, status[2]}, 32'h0);
        set_pin(1'b0);
        chk("R11 falling captured", capture, 32'h88);
        wr(3'd5, 32'h7);
    endtask

    task automatic t_single();
        wr(3'd0, E_BOTH | C_SINGLE);
        wr(3'd5, 32'h7);
        wr(3'd2, 32'h10);
        set_pin(1'b1);
        chk("R12 first capture", capture, 32'h10);
        wr(3'd2, 32'h20);
        set_pin(1'b0);
        chk("R12 held while flag set", capture, 32'h10);
        wr(3'd5, 32'h4);
        set_pin(1'b1);
        chk("R12 rearmed after clear", capture, 32'h20);
        wr(3'd5, 32'h7);
    endtask

    task automatic t_pindir();
        wr(3'd0, E_BOTH | C_PINOUT);
        chk("R13 output enable", {31'h0, pin_oe}, 32'h1);
        wr(3'd2, 32'h99);
        set_pin(1'b0);
        chk("R13 edge ignored as output", {31'h0, status[2]}, 32'h0);
        chk("R13 capture unchanged", capture, 32'h20);
        wr(3'd0, E_BOTH);
        chk("R13 output disabled", {31'h0, pin_oe}, 32'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cap_pin = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_count();
        t_prescale(0);
        t_prescale(2);
        t_prescale(7);
        t_oneshot();
        t_status();
        t_reload();
        t_trigger();
        t_match();
        t_pulse();
        t_level();
        t_toggle();
        t_capture();
        t_single();
        t_pindir();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule